// File: doc/BRIEF.md
# Panel power sequencer

This block drives the three enables of an embedded display panel (panel supply, video stream, backlight) and a flag telling the link side that the panel's auxiliary channel may be used. It enforces a minimum spacing between every pair of transitions. It also enforces a mandatory off-time before the panel supply may be re-applied. The controlling logic asks for the panel to be on or off with a single level. The link side reports when the main link is ready to carry video.

Every spacing is measured in ticks of an internal prescaler, which divides the system clock by `TICK_DIV`. Two sets of five 16-bit delay words are supplied, one from a register set and one from a configuration table. Each effective delay is the larger of the two words. A zero table word therefore leaves the register word in force. A delay is captured when its wait begins, so later changes to the inputs do not affect a wait that is already running.

The sequencer has eight named states. OFF is the idle state. PWRUP waits out the supply-to-aux delay. LINK waits for `link_ready`. BLON waits out the video-to-backlight delay. ON is fully on. BLOFF waits out the backlight-to-video-off delay. PWRDN waits out the video-off-to-supply-off delay. CYCLE is the power-cycle lockout.

The transitions are as follows:
- OFF→PWRUP on a power request.
- PWRUP→LINK when its delay expires.
- LINK→BLON on `link_ready`.
- BLON→ON when its delay expires.
- ON→BLOFF when the request drops.
- BLOFF→PWRDN when its delay expires.
- PWRDN→CYCLE when its delay expires.
- CYCLE→PWRUP, or CYCLE→OFF, when the lockout expires, depending on whether the request is still high.
- Abort paths: PWRUP→PWRDN and LINK→PWRDN, and BLON→BLOFF, when the request drops.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset all four enables and `busy` are low and `seq_state` is 0 (OFF). The power-cycle lockout counts as already expired, so `pnl_pwr_en` rises on the first clock edge that samples `pwr_req` high.
- R2: `aux_rdy` rises exactly Dup·TICK_DIV+1 cycles after `pnl_pwr_en` rises, where Dup is the effective delay in field 0. `aux_rdy` is never high while `pnl_pwr_en` is low.
- R3: In state LINK, `vid_en` rises on the edge that samples `link_ready` high. `vid_en` is only high while `aux_rdy` is high.
- R4: `bl_en` rises exactly Dblon·TICK_DIV+1 cycles after `vid_en` rises, where Dblon is field 1. `bl_en` is only high while `vid_en` is high.
- R5: On shutdown from ON, `bl_en` falls first. `vid_en` falls exactly Dbloff·TICK_DIV+1 cycles later, where Dbloff is field 2.
- R6: `pnl_pwr_en` and `aux_rdy` fall together, exactly Dpdn·TICK_DIV+1 cycles after `vid_en` falls, where Dpdn is field 3.
- R7: After `pnl_pwr_en` falls, it stays low for Dcyc·TICK_DIV+1 cycles, where Dcyc is field 4. This holds even when `pwr_req` is high throughout. A request raised during shutdown is held and served when the lockout ends.
- R8: Field i occupies bits [16·i+15:16·i] of `reg_dly` and of `tbl_dly`. Each effective delay is the maximum of the register word and the table word. A table word of 0 selects the register word.
- R9: If `pwr_req` drops in PWRUP or LINK, the next state is PWRDN (6) and video and backlight never turn on. If it drops in BLON, the next state is BLOFF (5) and the backlight never turns on.
- R10: `busy` is high while a delay wait is being timed, including the lockout. It is low in OFF after the lockout and in ON.
- R11: A delay is captured on entry to its wait. Changing the inputs afterwards does not change that wait.
- R12: `seq_state` encodes the states as follows: OFF=0, PWRUP=1, LINK=2, BLON=3, ON=4, BLOFF=5, PWRDN=6, CYCLE=7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Level request: 1 = panel on, 0 = panel off |
| link_ready | input | 1 | Main link is ready to carry video |
| reg_dly | input | 80 | Five register delay words in ticks (field order per R8) |
| tbl_dly | input | 80 | Five table delay words in ticks, 0 = absent |
| pnl_pwr_en | output | 1 | Panel supply enable |
| vid_en | output | 1 | Video stream enable |
| bl_en | output | 1 | Backlight enable |
| aux_rdy | output | 1 | Auxiliary channel may be used |
| busy | output | 1 | A delay wait is being timed |
| seq_state | output | 3 | Current sequencer state (encoding per R12) |

## Verification
The hardest situations to reach are a request that flips while a wait is running: an abort part-way through power-up, and a re-power request that arrives in the middle of shutdown. The stimulus reaches both by holding off until a chosen state or enable edge is visible at the ports, then flipping `pwr_req` at that moment. For the re-power case, the request is raised again while the backlight-off wait is still running, which forces the lockout to hold it. Every enable edge is compared in order against a queue of expected edges and their exact cycle spacing. Any edge that should not occur, such as video turning on after an abort, shows up as an unexpected event.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PWRUP = 3'd1,
        ST_LINK  = 3'd2,
        ST_BLON  = 3'd3,
        ST_ON    = 3'd4,
        ST_BLOFF = 3'd5,
        ST_PWRDN = 3'd6,
        ST_CYCLE = 3'd7
    } seq_st_e;

    localparam int NDLY     = 5;
    localparam int IX_UP    = 0;
    localparam int IX_BLON  = 1;
    localparam int IX_BLOFF = 2;
    localparam int IX_PWRDN = 3;
    localparam int IX_CYCLE = 4;

endpackage

// File: rtl/pps_delay_pick.sv
module pps_delay_pick #(
    parameter int W = 16,
    parameter int N = 5
) (
    input  logic [N*W-1:0] reg_dly,
    input  logic [N*W-1:0] tbl_dly,
    output logic [N*W-1:0] eff_dly
);

    for (genvar i = 0; i < N; i++) begin : g_pick
        logic [W-1:0] r_w, t_w;
        assign r_w = reg_dly[i*W +: W];
        assign t_w = tbl_dly[i*W +: W];
        // zero table word falls back to register word; otherwise larger wins
        assign eff_dly[i*W +: W] = (t_w == '0) ? r_w : ((t_w > r_w) ? t_w : r_w);
    end

endmodule

// File: rtl/pps_tick.sv
module pps_tick #(
    parameter int DIV = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = (pre_q == LAST);

endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    input  logic         tick,
    output logic         run,
    output logic         expired
);

    logic [W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            run   <= 1'b0;
        end else if (start) begin
            rem_q <= load;
            run   <= 1'b1;
        end else if (run) begin
            if (rem_q == '0) begin
                run <= 1'b0;
            end else if (tick) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign expired = run && (rem_q == '0);

    // R11: a running wait only counts down, never reloads without a start
    p_rem_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1));

    // R10: once a wait finishes, the timer stays idle until a new start
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> !run);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int TICK_DIV = 12500,
    parameter int DLY_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_req,
    input  logic                  link_ready,
    input  logic [NDLY*DLY_W-1:0] reg_dly,
    input  logic [NDLY*DLY_W-1:0] tbl_dly,
    output logic                  pnl_pwr_en,
    output logic                  vid_en,
    output logic                  bl_en,
    output logic                  aux_rdy,
    output logic                  busy,
    output logic [2:0]            seq_state
);

    seq_st_e st_q, st_d;

    logic [NDLY*DLY_W-1:0] eff_dly;
    logic [DLY_W-1:0]      load_val;
    logic                  tmr_start, tmr_exp, tmr_run, tick;
    logic                  is_wait_d;

    pps_delay_pick #(.W(DLY_W), .N(NDLY)) u_pick (
        .reg_dly (reg_dly),
        .tbl_dly (tbl_dly),
        .eff_dly (eff_dly)
    );

    pps_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_start),
        .tick  (tick)
    );

    pps_timer #(.W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .load    (load_val),
        .tick    (tick),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:   if (pwr_req) st_d = ST_PWRUP;
            ST_PWRUP: if (!pwr_req) st_d = ST_PWRDN;
                      else if (tmr_exp) st_d = ST_LINK;
            ST_LINK:  if (!pwr_req) st_d = ST_PWRDN;
                      else if (link_ready) st_d = ST_BLON;
            ST_BLON:  if (!pwr_req) st_d = ST_BLOFF;
                      else if (tmr_exp) st_d = ST_ON;
            ST_ON:    if (!pwr_req) st_d = ST_BLOFF;
            ST_BLOFF: if (tmr_exp) st_d = ST_PWRDN;
            ST_PWRDN: if (tmr_exp) st_d = ST_CYCLE;
            ST_CYCLE: if (tmr_exp) st_d = pwr_req ? ST_PWRUP : ST_OFF;
        endcase
    end

    // delay selection for the wait being entered
    always_comb begin
        is_wait_d = 1'b1;
        load_val  = '0;
        unique case (st_d)
            ST_PWRUP: load_val = eff_dly[IX_UP*DLY_W +: DLY_W];
            ST_BLON:  load_val = eff_dly[IX_BLON*DLY_W +: DLY_W];
            ST_BLOFF: load_val = eff_dly[IX_BLOFF*DLY_W +: DLY_W];
            ST_PWRDN: load_val = eff_dly[IX_PWRDN*DLY_W +: DLY_W];
            ST_CYCLE: load_val = eff_dly[IX_CYCLE*DLY_W +: DLY_W];
            ST_OFF, ST_LINK, ST_ON: is_wait_d = 1'b0;
        endcase
    end

    assign tmr_start = (st_d != st_q) && is_wait_d;

    // state register (reset leaves the lockout already expired)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pnl_pwr_en <= 1'b0;
            vid_en     <= 1'b0;
            bl_en      <= 1'b0;
            aux_rdy    <= 1'b0;
        end else begin
            pnl_pwr_en <= (st_d != ST_OFF) && (st_d != ST_CYCLE);
            vid_en     <= (st_d == ST_BLON) || (st_d == ST_ON) || (st_d == ST_BLOFF);
            bl_en      <= (st_d == ST_ON);
            if (aux_rdy) begin
                aux_rdy <= (st_d != ST_OFF) && (st_d != ST_CYCLE);
            end else begin
                aux_rdy <= (st_q == ST_PWRUP) && (st_d == ST_LINK);
            end
        end
    end

    assign busy      = tmr_run;
    assign seq_state = st_q;

    // R2: aux channel never flagged without panel supply
    p_aux_needs_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rdy |-> pnl_pwr_en);

    // R2: aux flag cannot rise on the same edge as the supply
    p_aux_after_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_rdy) |-> $past(pnl_pwr_en));

    // R3: video only with aux ready
    p_vid_needs_aux_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_en |-> aux_rdy);

    // R4: backlight only over running video
    p_bl_needs_vid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> vid_en);

    // R5: backlight already off before video drops
    p_bl_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_en) |-> $past(!bl_en));

    // R9: abort during power-up goes to the power-down wait with video off
    p_up_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PWRUP && !pwr_req) |=> (st_q == ST_PWRDN && !vid_en && !bl_en));

    // R10: no timer running while fully on
    p_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ON) |-> !busy);

endmodule

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;

    localparam int DIV = 4;
    localparam int W   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_req = 1'b0;
    logic          link_ready = 1'b0;
    logic [5*W-1:0] reg_dly;
    logic [5*W-1:0] tbl_dly;
    logic          pnl_pwr_en, vid_en, bl_en, aux_rdy, busy;
    logic [2:0]    seq_state;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_cyc = 0;
    logic [3:0] prev_v = 4'b0;
    logic [3:0] cur_v;

    int    eq_sig[$];
    int    eq_val[$];
    int    eq_gap[$];
    string eq_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    panel_pwr_seq #(.TICK_DIV(DIV), .DLY_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_req    (pwr_req),
        .link_ready (link_ready),
        .reg_dly    (reg_dly),
        .tbl_dly    (tbl_dly),
        .pnl_pwr_en (pnl_pwr_en),
        .vid_en     (vid_en),
        .bl_en      (bl_en),
        .aux_rdy    (aux_rdy),
        .busy       (busy),
        .seq_state  (seq_state)
    );

    function automatic logic [5*W-1:0] pack5(int up, int blon, int bloff, int pdn, int cyc5);
        return {W'(cyc5), W'(pdn), W'(bloff), W'(blon), W'(up)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sig: 0 pnl_pwr_en, 1 aux_rdy, 2 vid_en, 3 bl_en; gap -1 = not timed
    task automatic expect_evt(input int sig, input int val, input int gap, input string tag);
        eq_sig.push_back(sig);
        eq_val.push_back(val);
        eq_gap.push_back(gap);
        eq_tag.push_back(tag);
    endtask

    task automatic take_evt(input int sig, input int val);
        int gap;
        gap = cyc - last_cyc;
        last_cyc = cyc;
        checks++;
        if (eq_sig.size() == 0) begin
            failures++;
            $display("FAIL R9 unexpected edge actual sig=%0d val=%0d expected=none", sig, val);
        end else begin
            int es, ev, eg;
            string et;
            es = eq_sig.pop_front();
            ev = eq_val.pop_front();
            eg = eq_gap.pop_front();
            et = eq_tag.pop_front();
            if (es != sig || ev != val || (eg >= 0 && eg != gap)) begin
                failures++;
                $display("FAIL %s actual sig=%0d val=%0d gap=%0d expected sig=%0d val=%0d gap=%0d",
                         et, sig, val, gap, es, ev, eg);
            end
        end
    endtask

    // monitor: detects enable edges and scores them against the queue
    always @(negedge clk) begin
        cyc++;
        cur_v = {bl_en, vid_en, aux_rdy, pnl_pwr_en};
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (cur_v[i] !== prev_v[i]) take_evt(i, int'(cur_v[i]));
            end
        end
        prev_v = cur_v;
    end

    task automatic wait_state(input logic [2:0] s);
        int n = 0;
        while (seq_state !== s && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_pnl(input logic v);
        int n = 0;
        while (pnl_pwr_en !== v && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_bl(input logic v);
        int n = 0;
        while (bl_en !== v && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic expect_down(input int bloff_gap, input int pdn_gap, input string tag);
        expect_evt(3, 0, -1, tag);
        expect_evt(2, 0, bloff_gap, "R5");
        expect_evt(0, 0, pdn_gap, "R6");
        expect_evt(1, 0, 0, "R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        reg_dly = pack5(5, 3, 2, 4, 7);
        tbl_dly = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pnl_pwr_en", int'(pnl_pwr_en), 0);
        check("R1 vid_en", int'(vid_en), 0);
        check("R1 bl_en", int'(bl_en), 0);
        check("R1 aux_rdy", int'(aux_rdy), 0);
        check("R1 busy", int'(busy), 0);
        check("R12 reset state code", int'(seq_state), 0);

        // power-up from reset: no lockout wait
        link_ready = 1'b1;
        expect_evt(0, 1, -1, "R1");
        expect_evt(1, 1, 5*DIV+1, "R2");
        expect_evt(2, 1, 1, "R3");
        expect_evt(3, 1, 3*DIV+1, "R4");
        pwr_req = 1'b1;
        @(negedge clk);
        check("R1 supply on first edge", int'(pnl_pwr_en), 1);
        check("R10 busy in power-up", int'(busy), 1);
        check("R12 PWRUP code", int'(seq_state), 1);
        wait_state(3'd4);
        check("R12 ON code", int'(seq_state), 4);
        check("R10 busy low in ON", int'(busy), 0);

        // shutdown with a re-power request held by the lockout
        expect_down(2*DIV+1, 4*DIV+1, "R5");
        expect_evt(0, 1, 7*DIV+1, "R7");
        expect_evt(1, 1, 5*DIV+1, "R2");
        expect_evt(2, 1, 1, "R3");
        expect_evt(3, 1, 3*DIV+1, "R4");
        pwr_req = 1'b0;
        wait_bl(1'b0);
        pwr_req = 1'b1;
        wait_pnl(1'b0);
        @(negedge clk);
        check("R7 lockout state", int'(seq_state), 7);
        check("R10 busy in lockout", int'(busy), 1);
        wait_state(3'd4);

        // R8: table words mixed with register words
        tbl_dly = pack5(9, 1, 0, 6, 0);
        expect_down(2*DIV+1, 6*DIV+1, "R8");
        pwr_req = 1'b0;
        @(negedge clk);
        wait_state(3'd0);
        check("R10 busy low in OFF", int'(busy), 0);
        expect_evt(0, 1, -1, "R8");
        expect_evt(1, 1, 9*DIV+1, "R8");
        expect_evt(2, 1, 1, "R3");
        expect_evt(3, 1, 3*DIV+1, "R8");
        pwr_req = 1'b1;
        wait_state(3'd4);
        tbl_dly = '0;
        expect_down(2*DIV+1, 4*DIV+1, "R5");
        pwr_req = 1'b0;
        @(negedge clk);
        wait_state(3'd0);

        // R9: abort during power-up wait
        expect_evt(0, 1, -1, "R9");
        expect_evt(0, 0, -1, "R9");
        pwr_req = 1'b1;
        wait_pnl(1'b1);
        repeat (2) @(negedge clk);
        pwr_req = 1'b0;
        @(negedge clk);
        check("R9 abort to PWRDN", int'(seq_state), 6);
        check("R9 video stays off", int'(vid_en), 0);
        wait_state(3'd0);

        // R9: abort during backlight-on wait
        expect_evt(0, 1, -1, "R9");
        expect_evt(1, 1, 5*DIV+1, "R2");
        expect_evt(2, 1, 1, "R3");
        expect_evt(2, 0, -1, "R9");
        expect_evt(0, 0, 4*DIV+1, "R9");
        expect_evt(1, 0, 0, "R6");
        pwr_req = 1'b1;
        wait_state(3'd3);
        pwr_req = 1'b0;
        @(negedge clk);
        check("R9 abort to BLOFF", int'(seq_state), 5);
        check("R9 backlight stays off", int'(bl_en), 0);
        wait_state(3'd0);

        // R11: delay captured at start of the wait
        expect_evt(0, 1, -1, "R11");
        expect_evt(1, 1, 5*DIV+1, "R11");
        expect_evt(2, 1, 1, "R3");
        expect_evt(3, 1, 3*DIV+1, "R4");
        pwr_req = 1'b1;
        wait_pnl(1'b1);
        reg_dly = pack5(20, 3, 2, 4, 7);
        wait_state(3'd4);
        reg_dly = pack5(5, 3, 2, 4, 7);
        expect_down(2*DIV+1, 4*DIV+1, "R5");
        pwr_req = 1'b0;
        @(negedge clk);
        wait_state(3'd0);
        repeat (2) @(negedge clk);

        check("R6 all expected edges seen", eq_sig.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule